// File: doc/BRIEF.md
# Time-Stamped Sparse Column Store

This block sits behind one column of a sparsifying pixel front end. Each time step the front end may flag one 5-bit pixel word for keeping. The store files flagged words in a 38-word memory, each word with a header bit, and keeps a 15-bit step count as the time stamp of each data block. A flagged word that arrives fewer than 10 steps after the previous stored word joins the open block, so it needs no stamp of its own. A larger separation opens a new block with its own stamp. While any header bit is set, a data-present request is raised toward the readout multiplexer.

An extract strobe makes the column emit its whole contents as a stream of 6-bit words, one per clock. Each word is `{header, data[4:0]}`. Every block is framed by the two column address words, a zero gap word and the three stamp words, and long blocks are cut into groups with the stamp repeated. When the memory runs out of room, newer words displace the newest stored word. After the stream the column is empty and accepts new words again.

Top module: `sparse_col_mem`

## Requirements
- R1: After reset `out_word` is 6'h00 and `data_present` is 0. A word with header bit 0 always carries data 5'b00000.
- R2: `data_present` is 1 exactly while at least one word is stored. It rises on the cycle after the first accepted flagged word.
- R3: One clock after an extract strobe seen while `data_present` is 1, the stream starts and gives one word per clock: address high word (`COL_ADDR[9:5]`), address low word (`COL_ADDR[4:0]`), gap word 6'h20, stamp words holding bits [14:10], [9:5] and [4:0] of the step count of the block's first word, then the block's data words in arrival order. All of these words have header bit 1 (bit 5).
- R4: A flagged word whose step count exceeds that of the previously stored word by 1 to 9 joins the same block and gets no new framing.
- R5: A separation of 10 or more steps opens a new block. Blocks are streamed in arrival order, each with its full framing, and consecutive blocks are separated by exactly one idle word 6'h00.
- R6: Within a block, after every 6 data words, if more data words remain, the stream inserts the gap word and the three stamp words again. The header bit stays 1 throughout.
- R7: When all 38 words are in use, an accepted flagged word replaces the data of the newest stored word, and the word count is unchanged.
- R8: When all 8 block stamps are in use and a word would open a new block, that word replaces the data of the newest stored word instead.
- R9: An extract strobe while empty produces no stream. Flagged words that arrive while a stream is in progress are ignored. After the last data word the output returns to 6'h00 and `data_present` falls to 0.
- R10: The step count advances on every cycle with `step` high, whether or not a word is flagged and whether or not a stream is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Marks one time step |
| hit | input | 1 | The word on `hit_data` is flagged for storage (valid with `step`) |
| hit_data | input | 5 | Pixel word from the front end |
| extract | input | 1 | Readout strobe from the multiplexer |
| data_present | output | 1 | OR of all stored header bits |
| out_word | output | 6 | Stream word `{header, data}` |

## Verification
The assertions take for granted that `hit` is used only together with `step`, that `extract` arrives as a single pulse and is not repeated while a stream is running, and that the step count does not wrap between two stored words. The bench drives each step on the falling edge, drives one-cycle extract pulses only once the previous stream has finished, and keeps each run far below 32768 steps. Flagged words are driven during a stream only on purpose, to show that they are dropped.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int unsigned WORD_W = 5;
  localparam int unsigned TS_W   = 3 * WORD_W;

  typedef enum logic [3:0] {
    F_IDLE, F_AH, F_AL, F_GAP, F_T2, F_T1, F_T0, F_DATA, F_SEP
  } frm_st_e;

  // Steps elapsed between two step counts (modulo the counter width)
  function automatic logic [TS_W-1:0] step_sep(input logic [TS_W-1:0] now_t,
                                               input logic [TS_W-1:0] prev_t);
    return now_t - prev_t;
  endfunction

  // A word joins the open block when one exists and it lies close enough in time
  function automatic logic joins_block(input logic have_blk,
                                       input logic [TS_W-1:0] sep,
                                       input int unsigned merge_lim);
    return have_blk && (sep < TS_W'(merge_lim));
  endfunction

  function automatic logic [WORD_W:0] mk_word(input logic hdr,
                                              input logic [WORD_W-1:0] d);
    return {hdr, d};
  endfunction
endpackage

// File: rtl/scm_store.sv
module scm_store
  import scm_pkg::*;
#(
  parameter int unsigned DEPTH = 38,
  parameter int unsigned NBLK  = 8,
  parameter int unsigned MERGE = 10,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned BIW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int unsigned BW   = $clog2(NBLK + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              hit,
  input  logic [WORD_W-1:0] hit_data,
  input  logic              busy,
  input  logic              clr,
  input  logic [IW-1:0]     rd_idx,
  input  logic [BIW-1:0]    rd_blk,
  output logic [WORD_W:0]   rd_word,
  output logic              rd_nx_start,
  output logic [TS_W-1:0]   rd_ts,
  output logic [CW-1:0]     wcnt,
  output logic              present
);
  logic [WORD_W:0]   mem    [DEPTH];
  logic [TS_W-1:0]   ts_mem [NBLK];
  logic [DEPTH-1:0]  hdr_mem;
  logic [BW-1:0]     bcnt;
  logic [TS_W-1:0]   tnow, last_t;

  // named internal events
  logic wr_acc, new_blk, full, append, overwrite;
  logic [IW-1:0] wr_idx, last_idx, nx_idx;
  logic [CW-1:0] nx_cnt;

  assign wr_acc    = step & hit & ~busy;
  assign new_blk   = !joins_block(wcnt != '0, step_sep(tnow, last_t), MERGE);
  assign full      = (wcnt == CW'(DEPTH)) || (new_blk && bcnt == BW'(NBLK));
  assign append    = wr_acc & ~full;
  assign overwrite = wr_acc & full;
  assign wr_idx    = IW'(wcnt);
  assign last_idx  = IW'(wcnt - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tnow    <= '0;
      last_t  <= '0;
      wcnt    <= '0;
      bcnt    <= '0;
      hdr_mem <= '0;
    end else begin
      if (step) tnow <= tnow + 1'b1;
      if (clr) begin
        wcnt    <= '0;
        bcnt    <= '0;
        hdr_mem <= '0;
      end else if (append) begin
        wcnt            <= wcnt + 1'b1;
        hdr_mem[wr_idx] <= 1'b1;
        last_t          <= tnow;
        if (new_blk) bcnt <= bcnt + 1'b1;
      end else if (overwrite) begin
        last_t <= tnow;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (append) begin
      mem[wr_idx] <= mk_word(new_blk, hit_data);
      if (new_blk) ts_mem[BIW'(bcnt)] <= tnow;
    end else if (overwrite) begin
      mem[last_idx] <= mk_word(mem[last_idx][WORD_W], hit_data);
    end
  end

  assign present     = |hdr_mem;
  assign rd_word     = mem[rd_idx];
  assign rd_ts       = ts_mem[rd_blk];
  assign nx_cnt      = CW'(rd_idx) + 1'b1;
  assign nx_idx      = IW'(nx_cnt);
  assign rd_nx_start = (nx_cnt >= wcnt) ? 1'b0 : mem[nx_idx][WORD_W];

  // R7: the word count never exceeds the memory depth
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= CW'(DEPTH));
  // R7: a full memory stays full until it is streamed out
  p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wcnt == CW'(DEPTH) && !clr) |=> wcnt == CW'(DEPTH));
  // R2: header OR agrees with the word count
  p_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    present == (wcnt != '0));
  // R9: nothing is written while a stream runs
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr) |=> $stable(wcnt));
  // R8: block count never exceeds the stamp slots
  p_blk_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= BW'(NBLK));
endmodule

// File: rtl/scm_frame.sv
module scm_frame
  import scm_pkg::*;
#(
  parameter int unsigned DEPTH = 38,
  parameter int unsigned NBLK  = 8,
  parameter int unsigned GRP   = 6,
  parameter logic [2*WORD_W-1:0] COL_ADDR = 10'h2A5,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned BIW  = (NBLK > 1) ? $clog2(NBLK) : 1,
  localparam int unsigned GW   = $clog2(GRP + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            extract,
  input  logic            present,
  input  logic [CW-1:0]   wcnt,
  input  logic [WORD_W:0] rd_word,
  input  logic            rd_nx_start,
  input  logic [TS_W-1:0] rd_ts,
  output logic [IW-1:0]   rd_idx,
  output logic [BIW-1:0]  rd_blk,
  output logic            busy,
  output logic            clr,
  output logic [WORD_W:0] out_word
);
  frm_st_e       st;
  logic [GW-1:0] grp;
  logic          last_word;

  assign last_word = (CW'(rd_idx) + 1'b1) == wcnt;
  assign clr       = (st == F_DATA) && last_word;
  assign busy      = (st != F_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      rd_idx <= '0;
      rd_blk <= '0;
      grp    <= '0;
    end else begin
      unique case (st)
        F_IDLE: if (extract && present) begin
          st     <= F_AH;
          rd_idx <= '0;
          rd_blk <= '0;
        end
        F_AH:  st <= F_AL;
        F_AL:  st <= F_GAP;
        F_GAP: begin st <= F_T2; grp <= '0; end
        F_T2:  st <= F_T1;
        F_T1:  st <= F_T0;
        F_T0:  st <= F_DATA;
        F_DATA: begin
          grp <= grp + 1'b1;
          if (last_word) st <= F_IDLE;
          else begin
            rd_idx <= rd_idx + 1'b1;
            if (rd_nx_start) begin
              st     <= F_SEP;
              rd_blk <= rd_blk + 1'b1;
            end else if (grp + 1'b1 == GW'(GRP)) st <= F_GAP;
          end
        end
        F_SEP: st <= F_AH;
        default: st <= F_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      F_AH:   out_word = mk_word(1'b1, COL_ADDR[2*WORD_W-1:WORD_W]);
      F_AL:   out_word = mk_word(1'b1, COL_ADDR[WORD_W-1:0]);
      F_GAP:  out_word = mk_word(1'b1, '0);
      F_T2:   out_word = mk_word(1'b1, rd_ts[3*WORD_W-1:2*WORD_W]);
      F_T1:   out_word = mk_word(1'b1, rd_ts[2*WORD_W-1:WORD_W]);
      F_T0:   out_word = mk_word(1'b1, rd_ts[WORD_W-1:0]);
      F_DATA: out_word = mk_word(1'b1, rd_word[WORD_W-1:0]);
      default: out_word = '0;
    endcase
  end

  // R1: an idle word carries no data
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_word[WORD_W] |-> out_word[WORD_W-1:0] == '0);
  // R3: an accepted extract starts with the address high word
  p_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && extract && present) |=>
      out_word == {1'b1, COL_ADDR[2*WORD_W-1:WORD_W]});
  // R3: the address low word is followed by the gap word
  p_gap_after_al_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_word == {1'b1, COL_ADDR[WORD_W-1:0]} && st == F_AL) |=>
      out_word == {1'b1, {WORD_W{1'b0}}});
  // R6: a group never holds more than GRP data words
  p_group_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == F_DATA) |-> grp < GW'(GRP));
  // R9: an extract on an empty column starts nothing
  p_empty_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !present) |=> !out_word[WORD_W]);
endmodule

// File: rtl/sparse_col_mem.sv
module sparse_col_mem
  import scm_pkg::*;
#(
  parameter int unsigned DEPTH = 38,
  parameter int unsigned NBLK  = 8,
  parameter int unsigned MERGE = 10,
  parameter int unsigned GRP   = 6,
  parameter logic [2*WORD_W-1:0] COL_ADDR = 10'h2A5,
  localparam int unsigned IW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned BIW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              hit,
  input  logic [WORD_W-1:0] hit_data,
  input  logic              extract,
  output logic              data_present,
  output logic [WORD_W:0]   out_word
);
  logic [IW-1:0]   rd_idx;
  logic [BIW-1:0]  rd_blk;
  logic [WORD_W:0] rd_word;
  logic            rd_nx_start, busy, clr;
  logic [TS_W-1:0] rd_ts;
  logic [CW-1:0]   wcnt;

  scm_store #(.DEPTH(DEPTH), .NBLK(NBLK), .MERGE(MERGE)) u_store (
    .clk, .rst_n, .step, .hit, .hit_data, .busy, .clr,
    .rd_idx, .rd_blk, .rd_word, .rd_nx_start, .rd_ts, .wcnt,
    .present(data_present)
  );

  scm_frame #(.DEPTH(DEPTH), .NBLK(NBLK), .GRP(GRP), .COL_ADDR(COL_ADDR)) u_frame (
    .clk, .rst_n, .extract, .present(data_present), .wcnt,
    .rd_word, .rd_nx_start, .rd_ts, .rd_idx, .rd_blk, .busy, .clr, .out_word
  );
endmodule

// File: tb/tb_sparse_col_mem.sv
`timescale 1ns/1ps
module tb_sparse_col_mem;
  logic clk = 1'b0, rst_n = 1'b0, step = 1'b0, hit = 1'b0, extract = 1'b0;
  logic [4:0] hit_data = '0;
  logic data_present;
  logic [5:0] out_word;

  always #2 clk = ~clk;

  sparse_col_mem dut (.clk, .rst_n, .step, .hit, .hit_data, .extract,
                      .data_present, .out_word);

  int nchk = 0, nfail = 0;
  bit done = 0;

  // Bench model built from the requirements
  int md[64]; bit ms[64]; int mts[16];
  int mcnt = 0, mbcnt = 0, mlast = 0, mt = 0;
  int exq[256]; int elen;

  // {extract_after, hits_during_stream, gap[7:0], data[4:0]}
  localparam logic [14:0] TBL [20] = '{
    {1'b0,1'b0,8'd1,5'd3},  {1'b0,1'b0,8'd1,5'd7},  {1'b1,1'b0,8'd1,5'd11},  // R3
    {1'b0,1'b0,8'd1,5'd5},  {1'b1,1'b0,8'd9,5'd6},                           // R4
    {1'b0,1'b0,8'd1,5'd9},  {1'b1,1'b1,8'd10,5'd10},                         // R5 R9 R10
    {1'b0,1'b0,8'd1,5'd1},  {1'b0,1'b0,8'd1,5'd2},  {1'b0,1'b0,8'd1,5'd3},   // R6
    {1'b0,1'b0,8'd1,5'd4},  {1'b0,1'b0,8'd1,5'd5},  {1'b0,1'b0,8'd1,5'd6},
    {1'b0,1'b0,8'd1,5'd7},  {1'b0,1'b0,8'd1,5'd8},  {1'b0,1'b0,8'd1,5'd9},
    {1'b0,1'b0,8'd1,5'd10}, {1'b0,1'b0,8'd1,5'd11}, {1'b0,1'b0,8'd1,5'd12},
    {1'b1,1'b0,8'd1,5'd13}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic m_hit(input int d);
    bit nb, fl;
    nb = (mcnt == 0) || (((mt - mlast) & 32'h7FFF) >= 10);
    fl = (mcnt == 38) || (nb && mbcnt == 8);
    if (fl) md[mcnt-1] = d;
    else begin
      md[mcnt] = d; ms[mcnt] = nb;
      if (nb) begin mts[mbcnt] = mt; mbcnt++; end
      mcnt++;
    end
    mlast = mt;
  endtask

  task automatic drive(input bit h, input bit s, input int d);
    @(negedge clk);
    step = s; hit = h; hit_data = 5'(d);
    if (s) begin
      if (h) m_hit(d);
      mt++;
    end
  endtask

  task automatic push(input int gap, input int d);
    for (int k = 1; k < gap; k++) drive(0, 1, 0);
    drive(1, 1, d);
  endtask

  task automatic add_stamp(input int ts);
    exq[elen++] = 32; exq[elen++] = 32 | ((ts >> 10) & 31);
    exq[elen++] = 32 | ((ts >> 5) & 31); exq[elen++] = 32 | (ts & 31);
  endtask

  task automatic build_exp();
    int b, g;
    elen = 0; b = -1; g = 0;
    for (int i = 0; i < mcnt; i++) begin
      if (ms[i]) begin
        if (b >= 0) exq[elen++] = 0;
        b++;
        exq[elen++] = 32 | 21; exq[elen++] = 32 | 5;
        add_stamp(mts[b]); g = 0;
      end else if (g == 6) begin
        add_stamp(mts[b]); g = 0;
      end
      exq[elen++] = 32 | md[i]; g++;
    end
  endtask

  // Stream out and compare; R3 R4 R5 R6 R7 R8 checked word by word
  task automatic readout(input bit ign, input string req);
    build_exp();
    drive(0, 0, 0);
    extract = 1'b1;
    @(negedge clk);
    extract = 1'b0;
    if (ign) begin step = 1'b1; hit = 1'b1; hit_data = 5'd31; end
    for (int i = 0; i < elen; i++) begin
      chk(out_word == 6'(exq[i]), req, out_word, exq[i]);
      @(negedge clk);
    end
    if (ign) begin mt += elen; step = 1'b0; hit = 1'b0; end
    chk(out_word == 6'h00, "R9 end idle", out_word, 0);
    chk(data_present == 1'b0, "R9 empty after stream", data_present, 0);
    mcnt = 0; mbcnt = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_word == 6'h00, "R1 reset word", out_word, 0);
    chk(data_present == 1'b0, "R1 reset present", data_present, 0);

    // R9: extract on an empty column
    extract = 1'b1; @(negedge clk); extract = 1'b0;
    chk(out_word == 6'h00, "R9 empty extract", out_word, 0);
    @(negedge clk);
    chk(out_word == 6'h00, "R9 empty extract later", out_word, 0);

    // Table walk
    for (int e = 0; e < 20; e++) begin
      push(int'(TBL[e][12:5]), int'(TBL[e][4:0]));
      if (e == 0) begin
        drive(0, 0, 0);
        chk(data_present == 1'b1, "R2 present after first word", data_present, 1);
      end
      if (TBL[e][14]) readout(TBL[e][13], "R3 R4 R5 R6 R10 stream");
    end

    // R7: depth exhausted, later words replace the newest
    for (int i = 0; i < 40; i++) drive(1, 1, (i * 7) % 32);
    readout(0, "R7 full depth");

    // R8: stamp slots exhausted
    for (int i = 0; i < 9; i++) push(12, i + 20);
    readout(0, "R8 block slots full");

    // R10: idle steps advance the stamp
    for (int i = 0; i < 37; i++) drive(0, 1, 0);
    push(1, 17);
    readout(0, "R10 stamp after idle steps");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule